// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block tracks the position of an incremental rotary or linear encoder. It receives the two quadrature phase signals and the index mark as raw asynchronous inputs. It brings each one into the clock domain through a two-flop synchroniser. It then detects edges and keeps a signed-direction position count that wraps at its width.

A two-bit resolution select sets which edges are counted. The choices are rising edges of phase A only, both edges of phase A, rising edges of both phases, or every edge of both phases, which gives four counts per encoder line. The direction of each step comes from the phase order. A rising edge on the index input raises a one-cycle event. When the clear enable is set, the same index edge also resets the position to zero.

Top module: `qenc_counter`

## Requirements
- R1: While reset is asserted and just after it is released, `position` is 0, `dir_up` is 0 and `index_evt` is 0.
- R2: With `mode` = 2'b00, only rising edges of phase A change the count. Falling A edges and all B edges leave `position` unchanged.
- R3: With `mode` = 2'b01, both rising and falling edges of phase A change the count. B edges leave it unchanged.
- R4: With `mode` = 2'b10, rising edges of phase A and of phase B change the count. Falling edges of either phase leave it unchanged.
- R5: With `mode` = 2'b11, every edge of either phase changes the count.
- R6: A counted edge moves `position` by exactly one. The step is +1 with `dir_up` = 1 when A leads B, meaning the (A,B) sequence 00,10,11,01. The step is -1 with `dir_up` = 0 when B leads A. `dir_up` holds its value when no edge is counted.
- R7: A phase change made between clock edges shows on `position` at the third rising clock edge after it, and not at the second.
- R8: A cycle in which both synchronised phases change together is treated as invalid. It leaves `position` and `dir_up` unchanged.
- R9: A rising edge on `index_in` drives `index_evt` high for exactly one cycle, three clock edges after the input change.
- R10: When `idx_clr_en` = 1, the index edge sets `position` to 0 in the same cycle that `index_evt` rises. When `idx_clr_en` = 0, the index edge leaves `position` unchanged.
- R11: The count is modular. A step down from 0 gives all ones, and a step up from all ones gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_a_in | input | 1 | Encoder phase A, asynchronous |
| phase_b_in | input | 1 | Encoder phase B, asynchronous |
| index_in | input | 1 | Encoder index mark, asynchronous |
| mode | input | 2 | Counting resolution select, encoded as in R2 to R5 |
| idx_clr_en | input | 1 | Index edge clears the position when set |
| position | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last counted step, 1 for up |
| index_evt | output | 1 | One-cycle pulse on an index rising edge |

## Verification
The embedded properties assume the phase inputs change slowly compared with the clock. A synchronised phase level therefore stays valid for several cycles, and the resolution select is steady around each edge. The stimulus follows this. It changes at most one encoder line at a time, always on the falling clock edge, and then holds every input for at least three cycles before the next change. The one exception is a deliberate simultaneous change of both phases, which is made to exercise the invalid-transition rule.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a_in,
  input  logic             phase_b_in,
  input  logic             index_in,
  input  logic [1:0]       mode,
  input  logic             idx_clr_en,
  output logic [CNT_W-1:0] position,
  output logic             dir_up,
  output logic             index_evt
);

  logic [2:0] sync1, sync2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= {index_in, phase_b_in, phase_a_in};
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  wire a      = sync2[0];
  wire b      = sync2[1];
  wire a_chg  = sync2[0] ^ prev[0];
  wire b_chg  = sync2[1] ^ prev[1];
  wire a_rise = a_chg & a;
  wire b_rise = b_chg & b;
  wire idx_rise = sync2[2] & ~prev[2];
  wire idx_clr  = idx_rise & idx_clr_en;

  logic step, up;

  always_comb begin
    step = 1'b0;
    up   = 1'b0;
    if (!(a_chg && b_chg)) begin
      case (mode)
        2'b00: if (a_rise) begin step = 1'b1; up = ~b; end
        2'b01: if (a_chg)  begin step = 1'b1; up = a ^ b; end
        2'b10: begin
          if (a_rise)      begin step = 1'b1; up = ~b; end
          else if (b_rise) begin step = 1'b1; up = a;  end
        end
        default: begin
          if (a_chg)       begin step = 1'b1; up = a ^ b;    end
          else if (b_chg)  begin step = 1'b1; up = ~(a ^ b); end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position  <= '0;
      dir_up    <= 1'b0;
      index_evt <= 1'b0;
    end else begin
      index_evt <= idx_rise;
      if (step) dir_up <= up;
      if (idx_clr)   position <= '0;
      else if (step) position <= up ? position + 1'b1 : position - 1'b1;
    end
  end

  assert_step_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (position == $past(position)) || (position == $past(position) + 1'b1) ||
    (position == $past(position) - 1'b1) || (position == '0));

  assert_idx_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    index_evt |=> !index_evt);

  assert_idx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> (position == '0) && index_evt);

  assert_mode0_b_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && b_chg && !a_chg && !idx_clr) |=> $stable(position) && $stable(dir_up));

  assert_both_change_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg && !idx_clr) |=> $stable(position) && $stable(dir_up));

endmodule

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, pidx = 1'b0, clr_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] position;
  logic dir_up, index_evt;

  int checks = 0, errors = 0;
  int q = 0;
  logic [W-1:0] exp_pos = '0;
  logic exp_dir = 1'b0;

  always #2.5 clk = ~clk;

  qenc_counter #(.CNT_W(W)) u_qenc_counter (
    .clk(clk), .rst_n(rst_n), .phase_a_in(pa), .phase_b_in(pb), .index_in(pidx),
    .mode(mode), .idx_clr_en(clr_en), .position(position), .dir_up(dir_up),
    .index_evt(index_evt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic qa(input int s); return (s == 1 || s == 2); endfunction
  function automatic logic qb(input int s); return (s == 2 || s == 3); endfunction

  // edge kind: 0 A rise, 1 B rise, 2 A fall, 3 B fall
  function automatic int edge_kind(input int s, input bit fwd);
    if (fwd) return s;
    case (s)
      1: return 2;
      2: return 3;
      3: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit counted(input logic [1:0] m, input int k);
    case (m)
      2'b00: return k == 0;
      2'b01: return k == 0 || k == 2;
      2'b10: return k == 0 || k == 1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic settle(); repeat (3) @(posedge clk); #1; endtask

  task automatic move(input bit fwd, input string req);
    int k, nq;
    k  = edge_kind(q, fwd);
    nq = fwd ? (q + 1) % 4 : (q + 3) % 4;
    @(negedge clk);
    pa = qa(nq); pb = qb(nq); q = nq;
    if (counted(mode, k)) begin
      exp_pos = fwd ? exp_pos + 1'b1 : exp_pos - 1'b1;
      exp_dir = fwd;
    end
    settle();
    chk({req, " position"}, position, exp_pos);
    chk({req, " dir_up R6"}, dir_up, exp_dir);
  endtask

  task automatic index_pulse();
    @(negedge clk); pidx = 1'b1;
    settle();
    if (clr_en) exp_pos = '0;
    chk("R9 index_evt high", index_evt, 1);
    chk("R10 position at index", position, exp_pos);
    @(posedge clk); #1;
    chk("R9 index_evt single cycle", index_evt, 0);
    @(negedge clk); pidx = 1'b0;
    settle();
    chk("R9 no event on fall", index_evt, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk); #1;
    chk("R1 position in reset", position, 0);
    chk("R1 dir in reset", dir_up, 0);
    chk("R1 index_evt in reset", index_evt, 0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk("R1 position after reset", position, 0);

    // R11 wrap down, R5 all edges, R6 direction
    mode = 2'b11;
    move(1'b0, "R11 wrap down");
    move(1'b1, "R11 wrap up");
    // R7 latency
    @(negedge clk); pa = qa(1); pb = qb(1);
    repeat (2) @(posedge clk); #1;
    chk("R7 not at second edge", position, exp_pos);
    @(posedge clk); #1;
    q = 1; exp_pos = exp_pos + 1'b1; exp_dir = 1'b1;
    chk("R7 at third edge", position, exp_pos);
    // R8 simultaneous change: state 1 (10) -> state 3 (01)
    @(negedge clk); pa = qa(3); pb = qb(3); q = 3;
    settle();
    chk("R8 position unchanged", position, exp_pos);
    chk("R8 dir unchanged", dir_up, exp_dir);
    // directed mode sweeps
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int i = 0; i < 8; i++) move(1'b1, m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5");
      for (int i = 0; i < 8; i++) move(1'b0, m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5");
    end
    // R10 both settings
    clr_en = 1'b0; index_pulse();
    clr_en = 1'b1; index_pulse();
    // constrained random
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) mode = 2'($urandom);
      else if (r == 1) clr_en = ~clr_en;
      else if (r == 2) index_pulse();
      else move(($urandom % 3) != 0, "R2-R6 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule